// File: doc/BRIEF.md
# Tone-Envelope Control Message Transmitter

This block turns a short control message for outdoor satellite equipment into a tone-enable envelope. Each bit is sent as a tone-on interval followed by a tone-off interval. The ratio between the two intervals carries the bit value. A second output gates a free-running tone square wave with that envelope, so it can drive the line coupler directly.

The host places up to `MAX_LEN` bytes on `msg_data`, a byte count on `msg_len` and a burst choice on `burst_sel`, then pulses `start` for one cycle. The block then runs its sequence: quiet lead-in, each byte with a parity bit, a quiet gap, an optional burst with a quiet tail, and a one-cycle `done`. While the block is idle, `tone_on` holds the envelope high or low for continuous-tone signalling.

The controller has eight named states. `IDLE` goes to `LEAD` on start. `LEAD` goes to `MARK` if there are bytes to send, otherwise to `GAP`. `MARK` goes to `SPACE`. `SPACE` goes back to `MARK` for the next bit, or to `GAP` after the last byte, or to `TAIL` after a burst byte. `GAP` goes to `BURST` for the tone burst, to `MARK` for the byte burst, or to `FIN` when no burst is chosen. `BURST` goes to `TAIL`, `TAIL` goes to `FIN`, and `FIN` returns to `IDLE`. All durations are derived from `CLK_HZ` and are divided by `TIME_DIV`.

Top module: `dsq_envelope_tx`

## Requirements
- R1: After reset `busy`, `done`, `env` and `carrier` are all low while `tone_on` is low.
- R2: A one bit is SHORT_T ticks of envelope high then LONG_T ticks low. A zero bit is LONG_T high then SHORT_T low. LONG_T = 2*SHORT_T and SHORT_T is 0.5 ms of clock.
- R3: Byte k comes from `msg_data[8k+7:8k]`. Bytes go out in ascending k, and each byte goes out from bit 7 down to bit 0.
- R4: A ninth bit follows each byte. It equals 1 XOR all eight data bits (odd parity).
- R5: The envelope is low for QUIET_T ticks (16 ms) from the cycle after start. It is low again for QUIET_T ticks after the last message bit.
- R6: With `burst_sel` = 01 the gap is followed by BURST_T ticks (12.5 ms) high, then TAIL_T ticks (20 ms) low.
- R7: With `burst_sel` = 10 the gap is followed by byte 0xFF with its parity bit in the normal encoding, then TAIL_T ticks low.
- R8: With `burst_sel` = 00 or 11 no burst and no tail are sent, and `done` follows the gap.
- R9: With `msg_len` = 0 only the lead-in, the gap and the selected burst are sent.
- R10: A `msg_len` above MAX_LEN sends exactly MAX_LEN bytes.
- R11: `busy` is high from the cycle after an accepted start up to and including the single `done` cycle, which is the cycle after the last quiet interval. A `start` while busy is ignored.
- R12: While idle, `env` equals `tone_on`. While busy, `tone_on` has no effect.
- R13: `carrier` is `env` AND a square wave that toggles every TONE_HALF ticks. It is never high while `env` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to send the loaded message |
| msg_data | input | MAX_LEN*8 | Message bytes, byte k in bits 8k+7:8k |
| msg_len | input | LEN_W | Requested byte count, clipped to MAX_LEN |
| burst_sel | input | 2 | 00/11 none, 01 tone burst, 10 byte burst |
| tone_on | input | 1 | Continuous tone level while idle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| env | output | 1 | Tone-enable envelope |
| carrier | output | 1 | Envelope-gated tone square wave |

## Verification
The hardest case to reach is a start request or a `tone_on` change that arrives in the middle of a bit. The envelope is defined by its own state at that moment, so the stimulus must land inside a running sequence. The bench therefore re-pulses `start` with different data part-way through a message, and it randomises `tone_on` on every cycle of every message. The bench also builds the expected envelope tick by tick from the requirements for each message and compares it cycle by cycle. Random byte values and lengths, and directed zero-length, clipped-length and burst-variant messages, cover every path out of `GAP` and `SPACE`.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_MARK,
        ST_SPACE,
        ST_GAP,
        ST_BURST,
        ST_TAIL,
        ST_FIN
    } dsq_state_t;

    localparam logic [1:0] BSEL_NONE = 2'b00;
    localparam logic [1:0] BSEL_TONE = 2'b01;
    localparam logic [1:0] BSEL_BYTE = 2'b10;
endpackage

// File: rtl/dsq_tone_div.sv
module dsq_tone_div #(
    parameter int HALF = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic sq
);
    localparam int W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [W-1:0] LAST = W'(HALF - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sq  <= 1'b0;
        end else if (cnt == LAST) begin
            cnt <= '0;
            sq  <= ~sq;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R13
    half_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST);
endmodule

// File: rtl/dsq_span_timer.sv
module dsq_span_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dsq_bit_shifter.sv
module dsq_bit_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] ld_byte,
    input  logic       adv,
    output logic       cur_bit,
    output logic       last_bit
);
    logic [7:0] sh;
    logic [3:0] bcnt;
    logic       par;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            bcnt <= '0;
            par  <= 1'b1;
        end else if (load) begin
            sh   <= ld_byte;
            bcnt <= '0;
            par  <= 1'b1;
        end else if (adv) begin
            par  <= par ^ sh[7];
            sh   <= {sh[6:0], 1'b0};
            bcnt <= bcnt + 1'b1;
        end
    end

    assign last_bit = (bcnt == 4'd8);
    assign cur_bit  = last_bit ? par : sh[7];

    // R4
    slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) bcnt <= 4'd8);
    // R4
    no_adv_past_parity_chk: assert property (@(posedge clk) disable iff (!rst_n) adv |-> !last_bit);
endmodule

// File: rtl/dsq_envelope_tx.sv
module dsq_envelope_tx
    import dsq_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int TIME_DIV = 1,
    parameter int TONE_HZ  = 22_000,
    parameter int MAX_LEN  = 6,
    parameter int LEN_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [MAX_LEN*8-1:0] msg_data,
    input  logic [LEN_W-1:0]     msg_len,
    input  logic [1:0]           burst_sel,
    input  logic                 tone_on,
    output logic                 busy,
    output logic                 done,
    output logic                 env,
    output logic                 carrier
);
    localparam int MS_TICKS  = CLK_HZ / 1000;
    localparam int SHORT_RAW = CLK_HZ / 2000 / TIME_DIV;
    localparam int SHORT_T   = (SHORT_RAW < 1) ? 1 : SHORT_RAW;
    localparam int LONG_T    = 2 * SHORT_T;
    localparam int QUIET_RAW = MS_TICKS * 16 / TIME_DIV;
    localparam int QUIET_T   = (QUIET_RAW < 1) ? 1 : QUIET_RAW;
    localparam int BURST_RAW = MS_TICKS * 25 / 2 / TIME_DIV;
    localparam int BURST_T   = (BURST_RAW < 1) ? 1 : BURST_RAW;
    localparam int TAIL_RAW  = MS_TICKS * 20 / TIME_DIV;
    localparam int TAIL_T    = (TAIL_RAW < 1) ? 1 : TAIL_RAW;
    localparam int HALF_RAW  = CLK_HZ / (2 * TONE_HZ) / TIME_DIV;
    localparam int TONE_HALF = (HALF_RAW < 1) ? 1 : HALF_RAW;
    localparam int MAX_A     = (QUIET_T > TAIL_T) ? QUIET_T : TAIL_T;
    localparam int MAX_B     = (BURST_T > LONG_T) ? BURST_T : LONG_T;
    localparam int MAX_T     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W     = $clog2(MAX_T + 1);
    localparam int MSG_W     = MAX_LEN * 8;

    dsq_state_t state, state_n;

    logic [MSG_W-1:0] msg_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] bidx;
    logic [LEN_W-1:0] ld_idx;
    logic [1:0]       bsel_q;
    logic             in_burst;
    logic [CNT_W-1:0] tcnt;
    logic [CNT_W-1:0] cur_len;
    logic             span_end;
    logic             sh_load, sh_adv, ld_ff, next_byte, burst_byte_go;
    logic [7:0]       byte_sel, ld_byte;
    logic             cur_bit, last_bit;
    logic             sq;

    dsq_span_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(state_n != state), .cnt(tcnt)
    );

    dsq_bit_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .ld_byte(ld_byte),
        .adv(sh_adv), .cur_bit(cur_bit), .last_bit(last_bit)
    );

    dsq_tone_div #(.HALF(TONE_HALF)) u_tone (
        .clk(clk), .rst_n(rst_n), .sq(sq)
    );

    // Span length of the current state
    always_comb begin
        unique case (state)
            ST_LEAD, ST_GAP: cur_len = CNT_W'(QUIET_T);
            ST_MARK:         cur_len = cur_bit ? CNT_W'(SHORT_T) : CNT_W'(LONG_T);
            ST_SPACE:        cur_len = cur_bit ? CNT_W'(LONG_T) : CNT_W'(SHORT_T);
            ST_BURST:        cur_len = CNT_W'(BURST_T);
            ST_TAIL:         cur_len = CNT_W'(TAIL_T);
            default:         cur_len = CNT_W'(1);
        endcase
    end
    assign span_end = (tcnt == cur_len - 1'b1);

    // Byte fetch
    always_comb begin
        byte_sel = 8'h00;
        for (int i = 0; i < MAX_LEN; i++) begin
            if (ld_idx == LEN_W'(i)) byte_sel = msg_data_q_byte(i);
        end
    end
    function automatic logic [7:0] msg_data_q_byte(input int k);
        return msg_q[k*8 +: 8];
    endfunction
    assign ld_byte = ld_ff ? 8'hFF : byte_sel;

    // Next state and sequencing controls
    always_comb begin
        state_n       = state;
        sh_load       = 1'b0;
        sh_adv        = 1'b0;
        ld_ff         = 1'b0;
        next_byte     = 1'b0;
        burst_byte_go = 1'b0;
        ld_idx        = '0;
        unique case (state)
            ST_IDLE: if (start) state_n = ST_LEAD;
            ST_LEAD: if (span_end) begin
                if (len_q != '0) begin
                    sh_load = 1'b1;
                    state_n = ST_MARK;
                end else begin
                    state_n = ST_GAP;
                end
            end
            ST_MARK: if (span_end) state_n = ST_SPACE;
            ST_SPACE: if (span_end) begin
                if (!last_bit) begin
                    sh_adv  = 1'b1;
                    state_n = ST_MARK;
                end else if (in_burst) begin
                    state_n = ST_TAIL;
                end else if ((bidx + 1'b1) < len_q) begin
                    ld_idx    = bidx + 1'b1;
                    sh_load   = 1'b1;
                    next_byte = 1'b1;
                    state_n   = ST_MARK;
                end else begin
                    state_n = ST_GAP;
                end
            end
            ST_GAP: if (span_end) begin
                if (bsel_q == BSEL_TONE) begin
                    state_n = ST_BURST;
                end else if (bsel_q == BSEL_BYTE) begin
                    ld_ff         = 1'b1;
                    sh_load       = 1'b1;
                    burst_byte_go = 1'b1;
                    state_n       = ST_MARK;
                end else begin
                    state_n = ST_FIN;
                end
            end
            ST_BURST: if (span_end) state_n = ST_TAIL;
            ST_TAIL:  if (span_end) state_n = ST_FIN;
            ST_FIN:   state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Message capture and byte index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_q    <= '0;
            len_q    <= '0;
            bsel_q   <= BSEL_NONE;
            bidx     <= '0;
            in_burst <= 1'b0;
        end else if (state == ST_IDLE && start) begin
            msg_q    <= msg_data;
            len_q    <= (int'(msg_len) > MAX_LEN) ? LEN_W'(MAX_LEN) : msg_len;
            bsel_q   <= burst_sel;
            bidx     <= '0;
            in_burst <= 1'b0;
        end else begin
            if (next_byte)     bidx     <= bidx + 1'b1;
            if (burst_byte_go) in_burst <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        done    = (state == ST_FIN);
        env     = (state == ST_MARK) || (state == ST_BURST) || ((state == ST_IDLE) && tone_on);
        carrier = env & sq;
    end

    // R11
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> (!busy && !done));
    // R11
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
    // R11
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(done));
    // R5
    lead_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !env);
    // R8
    fin_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !$past(env));
    // R2
    span_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_FIN) |-> (tcnt < cur_len));
endmodule

// File: tb/tb_dsq_envelope_tx.sv
`timescale 1ns/1ps
module tb_dsq_envelope_tx;
    localparam int ML = 6;
    localparam int SH = 10, LG = 20, QT = 320, BT = 250, TL = 400;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tone_on = 1'b0;
    logic [ML*8-1:0] msg_data = '0;
    logic [3:0] msg_len = '0;
    logic [1:0] burst_sel = '0;
    logic busy, done, env, carrier;

    int checks = 0, errors = 0;
    bit finished = 0;
    bit exp_q[$];

    always #10 clk = ~clk;

    dsq_envelope_tx #(.CLK_HZ(50_000_000), .TIME_DIV(2500), .MAX_LEN(ML), .LEN_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .msg_data(msg_data), .msg_len(msg_len),
        .burst_sel(burst_sel), .tone_on(tone_on), .busy(busy), .done(done),
        .env(env), .carrier(carrier)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_n(input bit v, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(v);
    endtask

    task automatic push_bit(input bit b);
        if (b) begin push_n(1, SH); push_n(0, LG); end
        else   begin push_n(1, LG); push_n(0, SH); end
    endtask

    task automatic push_byte(input logic [7:0] d);
        bit p = 1;
        for (int i = 7; i >= 0; i--) begin
            push_bit(d[i]);
            p ^= d[i];
        end
        push_bit(p);
    endtask

    task automatic run_msg(input logic [ML*8-1:0] data, input int len, input logic [1:0] bsel,
                           input bit poke, input string tag);
        int eff, bad_at, bad_act, bad_exp, n;
        bit hs_ok, gate_ok;
        exp_q.delete();
        push_n(0, QT);
        eff = (len > ML) ? ML : len;
        for (int k = 0; k < eff; k++) push_byte(data[k*8 +: 8]);
        push_n(0, QT);
        if (bsel == 2'b01) begin push_n(1, BT); push_n(0, TL); end
        else if (bsel == 2'b10) begin push_byte(8'hFF); push_n(0, TL); end
        push_n(0, 1);
        n = exp_q.size();

        @(negedge clk);
        msg_data = data; msg_len = 4'(len); burst_sel = bsel; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bad_at = -1; bad_act = 0; bad_exp = 0; hs_ok = 1; gate_ok = 1;
        for (int i = 0; i < n; i++) begin
            if (bad_at < 0 && env !== exp_q[i]) begin
                bad_at = i; bad_act = int'(env); bad_exp = int'(exp_q[i]);
            end
            if (busy !== 1'b1 || done !== (i == n - 1)) hs_ok = 0;
            if (carrier && !env) gate_ok = 0;
            start = 1'b0;
            if (poke && i == n / 3) begin
                start = 1'b1; msg_data = ~data; burst_sel = ~bsel; msg_len = 4'd1;
            end
            tone_on = 1'($urandom);
            @(negedge clk);
        end
        check(bad_at < 0, $sformatf("%s envelope at tick %0d", tag, bad_at), bad_act, bad_exp);
        check(hs_ok, "R11 busy/done pulse", int'(hs_ok), 1);
        check(gate_ok, "R13 carrier gated by env", int'(gate_ok), 1);
        check(!busy && env === tone_on, "R12 idle env follows tone_on", int'(env), int'(tone_on));
        tone_on = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(!busy && !done && !env && !carrier, "R1 reset outputs", {busy, done, env, carrier}, 0);

        // R12 R13: continuous tone, carrier toggles every tick
        tone_on = 1'b1;
        @(negedge clk);
        begin
            bit ok = 1; logic prev = carrier;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (env !== 1'b1 || carrier === prev) ok = 0;
                prev = carrier;
            end
            check(ok, "R12/R13 continuous tone and carrier", int'(ok), 1);
        end
        tone_on = 1'b0;
        @(negedge clk);
        check(env === 1'b0 && carrier === 1'b0, "R12 tone off", int'(env), 0);

        run_msg(48'h0000_0000_00E2, 1, 2'b00, 0, "R2 R3 R4 R5 R8 single byte");
        run_msg(48'h0000_0000_5A3C, 2, 2'b11, 0, "R3 R4 R8 two bytes");
        run_msg('0, 0, 2'b01, 0, "R6 R9 tone burst only");
        run_msg('0, 0, 2'b10, 0, "R7 R9 byte burst only");
        run_msg('0, 0, 2'b00, 0, "R9 empty no burst");
        run_msg(48'hA1B2_C3D4_E5F6, 15, 2'b00, 0, "R10 clipped length");
        run_msg(48'h0000_0012_8001, 3, 2'b01, 1, "R11 start while busy ignored");
        for (int r = 0; r < 5; r++) begin
            logic [ML*8-1:0] d = {$urandom, $urandom};
            run_msg(d, int'($urandom_range(0, ML)), 2'($urandom), 0, "R2 R3 R4 R6 R7 random");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule